// File: doc/BRIEF.md
# Fire Module Compute Unit

This block evaluates one squeeze-expand stage of a compact convolutional network on a small feature map that sits entirely in on-chip buffers. It first reduces the input channels with a pointwise (1×1) squeeze convolution and stores the result in an internal buffer. From that buffer it computes two expand branches, a 1×1 convolution and a 3×3 convolution with stride 1 and zero padding of 1. Their results are stored side by side along the channel axis in an output buffer. Every convolution adds a per-channel bias, rescales by an arithmetic right shift, saturates to the 16-bit activation range and applies ReLU.

Before a run, the host fills three regions through one write port: the input map, the weights and the biases. It then pulses `start` and waits for `done`. The result is read through a combinational read port. A single shared multiply-accumulate unit does all the arithmetic, one product per cycle. A step whose activation is zero (this includes every padding tap) does not touch the accumulator.

Top module: `fire_unit`

## Requirements
- R1: The squeeze stage computes, for pixel p and squeeze channel s, post(Σ_ic in[p·CIN+ic]·w[s·CIN+ic], b[s]), where weight region offset 0 and bias offset 0 are used. The result is kept internally as the expand-stage input.
- R2: Output word p·(E1+E3)+c, for c in 0..E1−1, holds post(Σ_s sq[p][s]·w[SQ·CIN + c·SQ + s], b[SQ+c]). The pixel index is p = y·W + x, and `rd_data` shows the word at `rd_addr` in the same cycle.
- R3: Output word p·(E1+E3)+E1+k holds the 3×3 expand result for channel k. It uses weight w[SQ·CIN + E1·SQ + ((k·SQ+s)·3+ky)·3+kx] and bias b[SQ+E1+k]. Neighbour (y+ky−1, x+kx−1) reads as zero when it lies outside the map.
- R4: post(acc, b) adds the sign-extended bias to the 32-bit sum and shifts it arithmetically right by SHIFT. It then clamps values above 32767 to 32767 and values below zero to 0.
- R5: A multiply-accumulate step whose activation is zero, including a padding tap, leaves the accumulator unchanged.
- R6: When `ld_en` is high and the unit is idle, `ld_data` is written at `ld_addr` into the region chosen by `ld_sel`: 0 selects the input map, 1 selects weights (low 8 bits), 2 selects biases (low 8 bits), and 3 is discarded. Loads are ignored while `busy` is high.
- R7: `start` is taken only when idle. `busy` rises on the cycle after `start` is taken and stays high through the `done` cycle. A `start` during a run has no effect.
- R8: `done` is high for exactly one cycle. That cycle comes H·W·(SQ·CIN + E1·SQ + 9·E3·SQ) clock edges after the edge that takes `start`, directly after the last output word is written.
- R9: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load region: 0 map, 1 weights, 2 biases |
| ld_addr | input | AW | Word address within the region |
| ld_data | input | 16 | Load value |
| start | input | 1 | Begin a run (idle only) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | AW | Output buffer read address |
| rd_data | output | 16 | Output buffer word at `rd_addr` |

## Verification
Two things can happen in the same cycle. The host can act on the load port or on `start`, and a run can be accumulating at that moment. In one run the bench raises `start` and a map write together for one cycle in the middle of the squeeze stage. It then judges the result by exact `busy`/`done` timing on every clock and by every output word matching a model built from the unmodified map. Inside the datapath, the final product of one output also shares a cycle with the accumulator restart for the next. The saturating and zero-heavy runs stress this sharing, and each word is compared against the behavioural reference.

// File: rtl/fire_pkg.sv
// Shared types and arithmetic for the fire module compute unit.
// Assumes 32-bit accumulators, 8-bit signed coefficients, 16-bit activations.
package fire_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SQZ,
        PH_EX1,
        PH_EX3,
        PH_DONE
    } phase_e;

    localparam int ACT_W = 16;
    localparam int COEF_W = 8;
    localparam int ACC_W = 32;

    // Bias add, arithmetic rescale, clamp to activation range, rectify.
    function automatic logic signed [ACT_W-1:0] requant(
        input logic signed [ACC_W-1:0]  acc,
        input logic signed [COEF_W-1:0] bias,
        input int                        shamt
    );
        logic signed [ACC_W-1:0] sum;
        logic signed [ACC_W-1:0] scaled;
        sum    = acc + ACC_W'(bias);
        scaled = sum >>> shamt;
        if (scaled > 32'sd32767)
            return 16'sd32767;
        else if (scaled < 32'sd0)
            return 16'sd0;
        else
            return scaled[ACT_W-1:0];
    endfunction

endpackage

// File: rtl/fire_ram.sv
// Small register-array buffer with one write port and one combinational read port.
// Assumes AW >= $clog2(DEPTH); out-of-range reads return zero, out-of-range writes drop.
module fire_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];

    // Store a word when the address falls inside the array.
    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            mem[waddr[IW-1:0]] <= wdata;
    end

    // Return the addressed word, zero beyond the end.
    always_comb begin
        if (int'(raddr) < DEPTH)
            rdata = mem[raddr[IW-1:0]];
        else
            rdata = '0;
    end

endmodule

// File: rtl/fire_mac.sv
// Serial multiply-accumulate with zero-activation skipping and output requantisation.
// Assumes one product per step; 'first' restarts the sum, 'last' marks res_o as final.
module fire_mac
    import fire_pkg::*;
#(
    parameter int SHIFT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_i,
    input  logic                     first_i,
    input  logic                     last_i,
    input  logic signed [ACT_W-1:0]  act_i,
    input  logic signed [COEF_W-1:0] wt_i,
    input  logic signed [COEF_W-1:0] bias_i,
    output logic signed [ACT_W-1:0]  res_o
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] acc_nx;
    logic                    skip;

    // Form the running sum, bypassing the adder for zero activations.
    always_comb begin
        base   = first_i ? '0 : acc_q;
        skip   = (act_i == '0);
        prod   = ACC_W'(act_i) * ACC_W'(wt_i);
        acc_nx = skip ? base : (base + prod);
        res_o  = requant(acc_nx, bias_i, SHIFT);
    end

    // Hold the partial sum between steps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (step_i)
            acc_q <= acc_nx;
    end

    AST_ACC_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !first_i && act_i == '0) |=> (acc_q == $past(acc_q))); // R5

    AST_RESTART_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && first_i && act_i == '0) |=> (acc_q == '0)); // R5

    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_i) |-> !res_o[ACT_W-1]); // R4

endmodule

// File: rtl/fire_ctrl.sv
// Sequencer for squeeze, 1x1 expand and 3x3 expand phases; generates all buffer addresses.
// Assumes loop order (innermost first): kx, ky, input channel, output channel, x, y.
module fire_ctrl
    import fire_pkg::*;
#(
    parameter int H   = 4,
    parameter int W   = 4,
    parameter int CIN = 4,
    parameter int SQ  = 2,
    parameter int E1  = 2,
    parameter int E3  = 2,
    parameter int AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          done_o,
    output phase_e        phase_o,
    output logic          step_o,
    output logic          first_o,
    output logic          last_o,
    output logic          pad_o,
    output logic [AW-1:0] act_addr_o,
    output logic [AW-1:0] w_addr_o,
    output logic [AW-1:0] b_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic          sq_we_o,
    output logic          out_we_o
);
    localparam int ECH    = E1 + E3;
    localparam int W1_OFS = SQ * CIN;
    localparam int W3_OFS = W1_OFS + E1 * SQ;
    localparam int B1_OFS = SQ;
    localparam int B3_OFS = SQ + E1;

    phase_e ph;
    int y, x, oc, ic, ky, kx;

    int  nic, noc, ntap, off, iy, ix, pix, src, wa, ba, da;
    logic tap_last, ic_last, oc_last, run;

    // Loop bounds, neighbour coordinates and addresses for the current step.
    always_comb begin
        run  = (ph == PH_SQZ) || (ph == PH_EX1) || (ph == PH_EX3);
        nic  = (ph == PH_SQZ) ? CIN : SQ;
        noc  = (ph == PH_SQZ) ? SQ : ((ph == PH_EX1) ? E1 : E3);
        ntap = (ph == PH_EX3) ? 3 : 1;
        off  = (ph == PH_EX3) ? 1 : 0;
        tap_last = (ky == ntap - 1) && (kx == ntap - 1);
        ic_last  = (ic == nic - 1);
        oc_last  = (oc == noc - 1);
        iy  = y + ky - off;
        ix  = x + kx - off;
        pix = y * W + x;
        pad_o = (ph == PH_EX3) && (iy < 0 || iy >= H || ix < 0 || ix >= W);
        case (ph)
            PH_SQZ: begin
                src = pix * CIN + ic;
                wa  = oc * CIN + ic;
                ba  = oc;
                da  = pix * SQ + oc;
            end
            PH_EX1: begin
                src = pix * SQ + ic;
                wa  = W1_OFS + oc * SQ + ic;
                ba  = B1_OFS + oc;
                da  = pix * ECH + oc;
            end
            PH_EX3: begin
                src = pad_o ? 0 : ((iy * W + ix) * SQ + ic);
                wa  = W3_OFS + ((oc * SQ + ic) * 3 + ky) * 3 + kx;
                ba  = B3_OFS + oc;
                da  = pix * ECH + E1 + oc;
            end
            default: begin
                src = 0;
                wa  = 0;
                ba  = 0;
                da  = 0;
            end
        endcase
        act_addr_o = AW'(src);
        w_addr_o   = AW'(wa);
        b_addr_o   = AW'(ba);
        dst_addr_o = AW'(da);
        step_o     = run;
        first_o    = run && (ic == 0) && (ky == 0) && (kx == 0);
        last_o     = run && ic_last && tap_last;
        sq_we_o    = (ph == PH_SQZ) && last_o;
        out_we_o   = ((ph == PH_EX1) || (ph == PH_EX3)) && last_o;
        busy_o     = (ph != PH_IDLE);
        done_o     = (ph == PH_DONE);
        phase_o    = ph;
    end

    // Advance the nested loop counters and step through the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_IDLE;
            y  <= 0; x  <= 0; oc <= 0; ic <= 0; ky <= 0; kx <= 0;
        end else begin
            case (ph)
                PH_IDLE: if (start_i) ph <= PH_SQZ;
                PH_DONE: ph <= PH_IDLE;
                default: begin
                    if (!tap_last) begin
                        if (kx == ntap - 1) begin
                            kx <= 0;
                            ky <= ky + 1;
                        end else begin
                            kx <= kx + 1;
                        end
                    end else begin
                        kx <= 0;
                        ky <= 0;
                        if (!ic_last) begin
                            ic <= ic + 1;
                        end else begin
                            ic <= 0;
                            if (!oc_last) begin
                                oc <= oc + 1;
                            end else begin
                                oc <= 0;
                                if (x != W - 1) begin
                                    x <= x + 1;
                                end else begin
                                    x <= 0;
                                    if (y != H - 1) begin
                                        y <= y + 1;
                                    end else begin
                                        y <= 0;
                                        case (ph)
                                            PH_SQZ:  ph <= PH_EX1;
                                            PH_EX1:  ph <= PH_EX3;
                                            default: ph <= PH_DONE;
                                        endcase
                                    end
                                end
                            end
                        end
                    end
                end
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && ph == PH_SQZ)); // R7

    AST_PAD_ONLY_IN_EX3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_o |-> (ph == PH_EX3 && step_o)); // R3

endmodule

// File: rtl/fire_unit.sv
// Top of the fire module compute unit: load port, buffers, sequencer and shared MAC.
// Assumes loads happen only while idle; outputs are read combinationally after done.
module fire_unit
    import fire_pkg::*;
#(
    parameter int H     = 4,
    parameter int W     = 4,
    parameter int CIN   = 4,
    parameter int SQ    = 2,
    parameter int E1    = 2,
    parameter int E3    = 2,
    parameter int SHIFT = 6,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [AW-1:0] ld_addr,
    input  logic [15:0]   ld_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data
);
    localparam int IN_DEPTH  = H * W * CIN;
    localparam int SQ_DEPTH  = H * W * SQ;
    localparam int OUT_DEPTH = H * W * (E1 + E3);
    localparam int WT_DEPTH  = SQ * CIN + E1 * SQ + 9 * E3 * SQ;
    localparam int B_DEPTH   = SQ + E1 + E3;

    phase_e              phase;
    logic                step, first, last, pad, sq_we, out_we;
    logic [AW-1:0]       act_addr, w_addr, b_addr, dst_addr;
    logic                ld_ok, in_we, w_we, b_we;
    logic [ACT_W-1:0]    in_rd, sq_rd;
    logic [COEF_W-1:0]   w_rd, b_rd;
    logic signed [ACT_W-1:0] act, res;

    // Gate the load port so that a running job cannot be disturbed.
    always_comb begin
        ld_ok = ld_en && !busy;
        in_we = ld_ok && (ld_sel == 2'd0);
        w_we  = ld_ok && (ld_sel == 2'd1);
        b_we  = ld_ok && (ld_sel == 2'd2);
    end

    // Pick the activation source for this phase; padding taps read as zero.
    always_comb begin
        if (pad)
            act = '0;
        else if (phase == PH_SQZ)
            act = in_rd;
        else
            act = sq_rd;
    end

    fire_ctrl #(
        .H(H), .W(W), .CIN(CIN), .SQ(SQ), .E1(E1), .E3(E3), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .busy_o(busy), .done_o(done), .phase_o(phase),
        .step_o(step), .first_o(first), .last_o(last), .pad_o(pad),
        .act_addr_o(act_addr), .w_addr_o(w_addr), .b_addr_o(b_addr),
        .dst_addr_o(dst_addr), .sq_we_o(sq_we), .out_we_o(out_we)
    );

    fire_ram #(.DEPTH(IN_DEPTH), .WIDTH(ACT_W), .AW(AW)) u_in_buf (
        .clk(clk), .we(in_we), .waddr(ld_addr), .wdata(ld_data),
        .raddr(act_addr), .rdata(in_rd)
    );

    fire_ram #(.DEPTH(WT_DEPTH), .WIDTH(COEF_W), .AW(AW)) u_wt_buf (
        .clk(clk), .we(w_we), .waddr(ld_addr), .wdata(ld_data[COEF_W-1:0]),
        .raddr(w_addr), .rdata(w_rd)
    );

    fire_ram #(.DEPTH(B_DEPTH), .WIDTH(COEF_W), .AW(AW)) u_bias_buf (
        .clk(clk), .we(b_we), .waddr(ld_addr), .wdata(ld_data[COEF_W-1:0]),
        .raddr(b_addr), .rdata(b_rd)
    );

    fire_ram #(.DEPTH(SQ_DEPTH), .WIDTH(ACT_W), .AW(AW)) u_sq_buf (
        .clk(clk), .we(sq_we), .waddr(dst_addr), .wdata(res),
        .raddr(act_addr), .rdata(sq_rd)
    );

    fire_ram #(.DEPTH(OUT_DEPTH), .WIDTH(ACT_W), .AW(AW)) u_out_buf (
        .clk(clk), .we(out_we), .waddr(dst_addr), .wdata(res),
        .raddr(rd_addr), .rdata(rd_data)
    );

    fire_mac #(.SHIFT(SHIFT)) u_mac (
        .clk(clk), .rst_n(rst_n), .step_i(step), .first_i(first), .last_i(last),
        .act_i(act), .wt_i(w_rd), .bias_i(b_rd), .res_o(res)
    );

    AST_WRITES_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_we || out_we) |-> (busy && !done)); // R7

    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_we || w_we || b_we) |-> !busy); // R6

endmodule

// File: tb/tb_fire_unit.sv
// Self-checking bench: behavioural reference for the fire stage, per-clock handshake compare.
module tb_fire_unit;
    localparam int PERIOD = 10;
    localparam int H = 4, W = 4, CIN = 4, SQ = 2, E1 = 2, E3 = 2, SHIFT = 6, AW = 8;
    localparam int ECH = E1 + E3;
    localparam int NPIX = H * W;
    localparam int NIN = NPIX * CIN;
    localparam int NOUT = NPIX * ECH;
    localparam int NW = SQ * CIN + E1 * SQ + 9 * E3 * SQ;
    localparam int NB = SQ + E1 + E3;
    localparam int RUNLEN = NPIX * (SQ * CIN + E1 * SQ + 9 * E3 * SQ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0;
    logic [1:0] ld_sel = 2'd0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic start = 1'b0;
    logic busy, done;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;

    int in_m [NIN];
    int wt [NW];
    int bs [NB];
    int sqv [NPIX * SQ];
    int expv [NOUT];

    fire_unit #(.H(H), .W(W), .CIN(CIN), .SQ(SQ), .E1(E1), .E3(E3), .SHIFT(SHIFT), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
        .ld_data(ld_data), .start(start), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int want);
        checks++;
        if (got != want) begin
            failures++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, want);
        end
    endtask

    function automatic int post(input int acc, input int b);
        int s;
        s = (acc + b) >>> SHIFT;
        if (s > 32767) s = 32767;
        if (s < 0) s = 0;
        return s;
    endfunction

    // Reference: squeeze, then both expand branches concatenated by channel.
    task automatic build_ref();
        for (int p = 0; p < NPIX; p++)
            for (int s = 0; s < SQ; s++) begin
                int a = 0;
                for (int c = 0; c < CIN; c++) a += in_m[p * CIN + c] * wt[s * CIN + c];
                sqv[p * SQ + s] = post(a, bs[s]);
            end
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                int p = y * W + x;
                for (int c = 0; c < E1; c++) begin
                    int a = 0;
                    for (int s = 0; s < SQ; s++) a += sqv[p * SQ + s] * wt[SQ * CIN + c * SQ + s];
                    expv[p * ECH + c] = post(a, bs[SQ + c]);
                end
                for (int k = 0; k < E3; k++) begin
                    int a = 0;
                    for (int s = 0; s < SQ; s++)
                        for (int dy = 0; dy < 3; dy++)
                            for (int dx = 0; dx < 3; dx++) begin
                                int ny = y + dy - 1;
                                int nx = x + dx - 1;
                                if (ny >= 0 && ny < H && nx >= 0 && nx < W)
                                    a += sqv[(ny * W + nx) * SQ + s] *
                                         wt[SQ * CIN + E1 * SQ + ((k * SQ + s) * 3 + dy) * 3 + dx];
                            end
                    expv[p * ECH + E1 + k] = post(a, bs[SQ + E1 + k]);
                end
            end
    endtask

    task automatic load_word(input logic [1:0] sel, input int addr, input int val);
        @(negedge clk);
        ld_en = 1'b1;
        ld_sel = sel;
        ld_addr = AW'(addr);
        ld_data = 16'(val);
    endtask

    // Loads all three regions, plus one discarded write on selector 3 (R6).
    task automatic load_all();
        for (int i = 0; i < NIN; i++) load_word(2'd0, i, in_m[i]);
        for (int i = 0; i < NW; i++) load_word(2'd1, i, wt[i]);
        for (int i = 0; i < NB; i++) load_word(2'd2, i, bs[i]);
        load_word(2'd3, 0, 16'h7fff);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // One run: busy/done compared every clock, then every output word.
    task automatic run_and_check(input string tag, input bit disturb);
        build_ref();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int n = 1; n <= RUNLEN + 2; n++) begin
            @(posedge clk);
            #1;
            check("R7", $sformatf("busy@%0d", n), int'(busy), (n <= RUNLEN) ? 1 : 0);
            check("R8", $sformatf("done@%0d", n), int'(done), (n == RUNLEN) ? 1 : 0);
            if (disturb && n == 100) begin
                start = 1'b1;
                ld_en = 1'b1;
                ld_sel = 2'd0;
                ld_addr = '0;
                ld_data = 16'h1234;
            end
            if (disturb && n == 101) begin
                start = 1'b0;
                ld_en = 1'b0;
            end
        end
        for (int i = 0; i < NOUT; i++) begin
            string req;
            rd_addr = AW'(i);
            #1;
            if (tag != "") req = tag;
            else if ((i % ECH) < E1) req = "R1 R2";
            else req = "R1 R3";
            check(req, $sformatf("out[%0d]", i), int'($signed(rd_data)), expv[i]);
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R9", "busy in reset", int'(busy), 0);
        check("R9", "done in reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R9", "busy after reset", int'(busy), 0);

        // Mixed-sign random map.
        for (int i = 0; i < NIN; i++) in_m[i] = int'($urandom_range(400)) - 200;
        for (int i = 0; i < NW; i++) wt[i] = int'($urandom_range(80)) - 40;
        for (int i = 0; i < NB; i++) bs[i] = int'($urandom_range(255)) - 128;
        load_all();
        run_and_check("", 1'b0);

        // Mostly zero activations: skipping must not change results (R5).
        for (int i = 0; i < NIN; i++)
            in_m[i] = ($urandom_range(3) == 0) ? int'($urandom_range(400)) - 200 : 0;
        load_all();
        run_and_check("R5", 1'b0);

        // Extreme inputs drive both clamp directions (R4).
        for (int i = 0; i < NIN; i++) in_m[i] = (i % 3 == 0) ? -32768 : 32767;
        for (int i = 0; i < NW; i++) wt[i] = (i % 4 == 1) ? -128 : 127;
        for (int i = 0; i < NB; i++) bs[i] = (i % 2 == 0) ? 127 : -128;
        load_all();
        run_and_check("R4", 1'b0);

        // Start and load arriving mid-run must be ignored (R6, R7).
        for (int i = 0; i < NIN; i++) in_m[i] = int'($urandom_range(400)) - 200;
        for (int i = 0; i < NW; i++) wt[i] = int'($urandom_range(80)) - 40;
        load_all();
        run_and_check("R6 R7", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule